// File: doc/BRIEF.md
# Indirect Flash Read Transfer Controller

This block moves a block of data from serial flash into the read half of an on-chip word FIFO, from which a host drains it through a data port. Software programs a start byte address, a byte count and a watermark, then sets the start bit in the control register. The block issues word-wide read requests, one at a time, to a simple request/response flash-side port and pushes each returned word into the FIFO.

The host watches a live fill level, counted in FIFO words, and pops words as they arrive. When the read partition is full, fetching pauses until the host pops a word. The transfer finishes only when every word has been fetched and drained. At that moment the busy flag drops and a sticky done flag rises, which software clears by writing one to it. A cancel bit abandons an active transfer. The serial waveform itself sits behind the flash-side port and is not part of this block.

Top module: `flash_ird_ctrl`

## Requirements
- R1: After reset, busy, done, the fill level and `fl_req` are 0, and the partition register reads DEPTH/2.
- R2: Register word 0 is the control register. Bit 0 is start, bit 1 is cancel, bit 2 is busy (read-only), bit 5 is done and bit 6 is the watermark flag. Writing start while idle with a nonzero byte count sets busy on the next cycle. Writing start while busy has no effect, and so does writing start together with cancel. Words 1, 2, 3, 4 and 5 hold the start address, the byte count, the watermark, the partition size and the fill level (read-only).
- R3: At most one flash request is outstanding. `fl_req` stays high with a stable `fl_addr` until `fl_valid`. The addresses run start, start+4, start+8, and so on. A transfer of N bytes issues ceil(N/4) requests, so a partial last word is fetched whole.
- R4: `rd_data` shows the oldest FIFO word, and words leave in arrival order. A pop while the FIFO is empty is ignored.
- R5: Register word 5, bits 15:0, reads the number of words held in the FIFO.
- R6: No new request is raised while the fill level is at or above the read capacity. Fetching resumes after the host pops a word.
- R7: On the clock edge that pops the last word of a transfer, busy clears and done sets together.
- R8: Writing 1 to control bit 5 clears done. Writing 0 there leaves done unchanged.
- R9: Cancel while busy clears busy, empties the FIFO, drops the outstanding request and does not set done. A flash response that arrives with no request pending is discarded.
- R10: Control bit 6 reads 1 exactly when the fill level is greater than the watermark register.
- R11: Start with a byte count of 0 sets done at once, and busy stays 0.
- R12: The read capacity equals the partition register (a field of clog2(DEPTH+1) bits) when it lies in 1..DEPTH, and equals DEPTH otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| rd_pop | input | 1 | Host pops the oldest FIFO word |
| rd_data | output | DATA_W | Oldest FIFO word |
| fl_req | output | 1 | Flash read request, held until answered |
| fl_addr | output | ADDR_W | Byte address of the requested word |
| fl_valid | input | 1 | Flash response strobe |
| fl_rdata | input | DATA_W | Flash response word |

## Verification
The bench builds the block with DEPTH=8, so the default read partition holds only four words. A ten-word transfer with no host pops therefore reaches the stall within a few dozen cycles, and clearing the partition register to 0 makes the whole eight-word FIFO the capacity. The small depth also makes pointer wrap-around happen many times over the run. A flash stub with a three-cycle response latency leaves a window in which a cancel can land on a pending request, and it sends a stale response back after the cancel.

// File: rtl/flash_ird_ctrl.sv
module flash_ird_ctrl #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              rd_pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              fl_req,
  output logic [ADDR_W-1:0] fl_addr,
  input  logic              fl_valid,
  input  logic [DATA_W-1:0] fl_rdata
);
  localparam int PW    = $clog2(DEPTH);
  localparam int LW    = $clog2(DEPTH + 1);
  localparam int BYTES = DATA_W / 8;
  localparam int BSH   = $clog2(BYTES);
  localparam int WW    = CNT_W + 1;
  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);
  localparam logic [PW-1:0] LAST_P  = PW'(DEPTH - 1);

  logic              busy, done, pend;
  logic [ADDR_W-1:0] start_q, addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [15:0]       wm_q;
  logic [LW-1:0]     part_q, level, cap;
  logic [WW-1:0]     total, fetched, popped;
  logic [PW-1:0]     wp, rp;
  logic [DATA_W-1:0] mem [DEPTH];

  wire ctrl_w   = reg_wr && reg_addr == 3'd0;
  wire cancel_w = ctrl_w && reg_wdata[1];
  wire start_w  = ctrl_w && reg_wdata[0] && !reg_wdata[1];
  wire flush    = busy && cancel_w;
  wire go       = !busy && start_w;
  wire go_load  = go && cnt_q != '0;
  wire push     = fl_valid && pend && !flush;
  wire pop_fire = rd_pop && level != '0 && !flush;
  wire last_pop = busy && pop_fire && (popped + WW'(1) == total);
  wire issue    = busy && !pend && !flush && fetched < total && level < cap;
  wire wm_hit   = 16'(level) > wm_q;

  assign cap     = (part_q != '0 && part_q <= DEPTH_L) ? part_q : DEPTH_L;
  assign fl_req  = pend;
  assign fl_addr = addr_q;
  assign rd_data = mem[rp];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == LAST_P) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk)
    if (push) mem[wp] <= fl_rdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; level <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; level <= '0;
    end else begin
      if (push)     wp <= nxt(wp);
      if (pop_fire) rp <= nxt(rp);
      level <= level + LW'(push) - LW'(pop_fire);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; pend <= 1'b0; done <= 1'b0;
      total <= '0; fetched <= '0; popped <= '0; addr_q <= '0;
    end else begin
      if (flush)         busy <= 1'b0;
      else if (go_load)  busy <= 1'b1;
      else if (last_pop) busy <= 1'b0;

      if (flush || push) pend <= 1'b0;
      else if (issue)    pend <= 1'b1;

      if (go_load) begin
        total   <= (WW'(cnt_q) + WW'(BYTES - 1)) >> BSH;
        fetched <= '0;
        popped  <= '0;
        addr_q  <= start_q;
      end else begin
        if (push) begin
          fetched <= fetched + WW'(1);
          addr_q  <= addr_q + ADDR_W'(BYTES);
        end
        if (busy && pop_fire) popped <= popped + WW'(1);
      end

      if (last_pop || (go && cnt_q == '0)) done <= 1'b1;
      else if (ctrl_w && reg_wdata[5])     done <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      start_q <= '0; cnt_q <= '0; wm_q <= '0;
      part_q  <= LW'(DEPTH / 2);
    end else if (reg_wr) begin
      case (reg_addr)
        3'd1: start_q <= ADDR_W'(reg_wdata);
        3'd2: cnt_q   <= CNT_W'(reg_wdata);
        3'd3: wm_q    <= reg_wdata[15:0];
        3'd4: part_q  <= reg_wdata[LW-1:0];
        default: ;
      endcase
    end

  always_comb
    case (reg_addr)
      3'd0:    reg_rdata = {25'd0, wm_hit, done, 2'b00, busy, 2'b00};
      3'd1:    reg_rdata = 32'(start_q);
      3'd2:    reg_rdata = 32'(cnt_q);
      3'd3:    reg_rdata = {16'd0, wm_q};
      3'd4:    reg_rdata = 32'(part_q);
      3'd5:    reg_rdata = {16'd0, 16'(level)};
      default: reg_rdata = '0;
    endcase
endmodule

// File: rtl/flash_ird_ctrl_chk.sv
module flash_ird_ctrl_chk #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              busy,
  input logic              done,
  input logic              fl_req,
  input logic              fl_valid,
  input logic [ADDR_W-1:0] fl_addr,
  input logic [LW-1:0]     level,
  input logic [LW-1:0]     cap
);
  wire ctrl_c   = reg_wr && reg_addr == 3'd0;
  wire cancel_c = ctrl_c && reg_wdata[1];

  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req && !fl_valid && !cancel_c |=> fl_req && $stable(fl_addr));

  a_r6_no_issue_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_req) |-> $past(level) < $past(cap));

  a_r5_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  a_r7_done_with_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy);

  a_r9_cancel_flush: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cancel_c |=> !busy && level == '0 && !fl_req && !$rose(done));

  a_r8_done_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    done && !busy && ctrl_c && reg_wdata[5] && !reg_wdata[0] |=> !done);
endmodule

bind flash_ird_ctrl flash_ird_ctrl_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .busy(busy), .done(done), .fl_req(fl_req),
  .fl_valid(fl_valid), .fl_addr(fl_addr), .level(level), .cap(cap)
);

// File: tb/flash_ird_ctrl_tb.sv
module flash_ird_ctrl_tb;
  localparam int DEPTH = 8;
  localparam int LAT   = 3;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0, rd_pop = 1'b0, fl_valid = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, fl_rdata = '0;
  logic [31:0] reg_rdata, rd_data, fl_addr;
  logic        fl_req;

  int checks = 0, fails = 0, reqs = 0;

  always #4 clk = ~clk;

  flash_ird_ctrl #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_pop(rd_pop),
    .rd_data(rd_data), .fl_req(fl_req), .fl_addr(fl_addr),
    .fl_valid(fl_valid), .fl_rdata(fl_rdata)
  );

  function automatic logic [31:0] fdat(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, ~a[15:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // flash stub: fixed latency, one response per request
  logic        infl = 1'b0;
  int          lcnt = 0;
  logic [31:0] la = '0;
  always @(negedge clk) begin
    if (fl_valid) fl_valid <= 1'b0;
    else if (!infl && fl_req && rst_n) begin
      infl <= 1'b1; lcnt <= LAT; la <= fl_addr; reqs <= reqs + 1;
    end else if (infl) begin
      if (lcnt == 1) begin
        fl_valid <= 1'b1; fl_rdata <= fdat(la); infl <= 1'b0;
      end
      lcnt <= lcnt - 1;
    end
  end

  // behavioural reference model
  logic [31:0] mq[$];
  int m_busy, m_done, m_pend, m_total, m_fetched, m_popped, m_part, m_cnt, m_wm;
  logic [31:0] m_addr, m_start;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_busy = 0; m_done = 0; m_pend = 0; m_total = 0;
      m_fetched = 0; m_popped = 0; m_part = DEPTH / 2; m_cnt = 0; m_wm = 0;
      m_addr = 0; m_start = 0;
    end else begin
      int lvl, cap, dset;
      bit ctrlw, cancel, start, popf, push;
      lvl    = mq.size();
      cap    = (m_part >= 1 && m_part <= DEPTH) ? m_part : DEPTH;
      ctrlw  = reg_wr && reg_addr == 0;
      cancel = ctrlw && reg_wdata[1];
      start  = ctrlw && reg_wdata[0] && !reg_wdata[1];
      popf   = rd_pop && lvl > 0;
      push   = fl_valid && m_pend != 0;
      dset   = 0;
      if (m_busy != 0 && cancel) begin
        m_busy = 0; m_pend = 0; mq.delete();
      end else if (m_busy == 0 && start) begin
        if (m_cnt == 0) dset = 1;
        else begin
          m_busy = 1; m_total = (m_cnt + 3) / 4; m_fetched = 0;
          m_popped = 0; m_addr = m_start; m_pend = 0;
        end
      end else if (m_busy != 0) begin
        if (popf) begin
          void'(mq.pop_front()); m_popped++;
          if (m_popped == m_total) begin m_busy = 0; dset = 1; end
        end
        if (push) begin
          mq.push_back(fl_rdata); m_fetched++; m_addr += 4; m_pend = 0;
        end else if (m_pend == 0 && m_fetched < m_total && lvl < cap && (m_busy != 0 || dset == 1))
          m_pend = 1;
      end else if (popf) void'(mq.pop_front());
      if (dset != 0) m_done = 1;
      else if (ctrlw && reg_wdata[5]) m_done = 0;
      if (reg_wr) case (reg_addr)
        3'd1: m_start = reg_wdata;
        3'd2: m_cnt   = int'(reg_wdata[15:0]);
        3'd3: m_wm    = int'(reg_wdata[15:0]);
        3'd4: m_part  = int'(reg_wdata[3:0]);
        default: ;
      endcase
    end
    #1;
    if (rst_n) begin
      chk("R3 fl_req vs model", 32'(fl_req), 32'(m_pend));
      if (m_pend != 0) chk("R3 fl_addr vs model", fl_addr, m_addr);
      if (mq.size() > 0) chk("R4 rd_data vs model", rd_data, mq[0]);
      if (reg_addr == 0 && !reg_wr)
        chk("R2 ctrl vs model", reg_rdata,
            32'((m_busy << 2) | (m_done << 5) | (((mq.size() > m_wm) ? 1 : 0) << 6)));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    reg_addr = a; #1;
    chk(tag, reg_rdata, exp);
    reg_addr = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pop_chk(input string tag, input logic [31:0] exp);
    while (mq.size() == 0) @(negedge clk);
    chk(tag, rd_data, exp);
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  task automatic drain(input string tag, input logic [31:0] base, input int from, input int n);
    for (int k = from; k < n; k++) pop_chk(tag, fdat(base + 32'(4 * k)));
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int r0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    rd_chk("R1 ctrl after reset", 3'd0, 32'h0);
    rd_chk("R1 partition after reset", 3'd4, 32'd4);
    rd_chk("R1 level after reset", 3'd5, 32'd0);
    chk("R1 fl_req after reset", 32'(fl_req), 32'd0);

    // R3 R4 R7: 10 bytes -> 3 words, partial last word fetched whole
    r0 = reqs;
    wr(3'd1, 32'h100); wr(3'd2, 32'd10); wr(3'd0, 32'h1);
    rd_chk("R2 busy after start", 3'd0, 32'h4);
    drain("R4 data order", 32'h100, 0, 3);
    rd_chk("R7 done and not busy", 3'd0, 32'h20);
    chk("R3 ceil word count", 32'(reqs - r0), 32'd3);
    // R8 write-one-to-clear
    wr(3'd0, 32'h0);
    rd_chk("R8 writing 0 keeps done", 3'd0, 32'h20);
    wr(3'd0, 32'h20);
    rd_chk("R8 writing 1 clears done", 3'd0, 32'h0);

    // R6 R10 stall at default capacity 4
    r0 = reqs;
    wr(3'd3, 32'd3); wr(3'd1, 32'h200); wr(3'd2, 32'd40); wr(3'd0, 32'h1);
    idle(60);
    rd_chk("R6 level held at capacity", 3'd5, 32'd4);
    rd_chk("R5 R6 level in words", 3'd5, 32'd4);
    chk("R6 no request while full", 32'(fl_req), 32'd0);
    chk("R6 requests stop at capacity", 32'(reqs - r0), 32'd4);
    rd_chk("R10 watermark flag above", 3'd0, 32'h44);
    wr(3'd3, 32'd4);
    rd_chk("R10 watermark flag at equal", 3'd0, 32'h04);
    pop_chk("R4 first stalled word", fdat(32'h200));
    idle(20);
    chk("R6 fetch resumes after pop", 32'(reqs - r0), 32'd5);
    rd_chk("R6 refilled", 3'd5, 32'd4);
    drain("R4 stalled stream", 32'h200, 1, 10);
    rd_chk("R7 done after ten words", 3'd0, 32'h20);
    wr(3'd0, 32'h20);

    // R12 partition 0 -> full depth, partition 6 -> six words
    wr(3'd3, 32'd100);
    wr(3'd4, 32'd0); wr(3'd1, 32'h300); wr(3'd2, 32'd32); wr(3'd0, 32'h1);
    idle(80);
    rd_chk("R12 partition 0 uses whole depth", 3'd5, 32'd8);
    drain("R4 full-depth stream", 32'h300, 0, 8);
    wr(3'd0, 32'h20);
    wr(3'd4, 32'd6); wr(3'd1, 32'h340); wr(3'd2, 32'd28); wr(3'd0, 32'h1);
    idle(60);
    rd_chk("R12 partition 6", 3'd5, 32'd6);
    drain("R4 partition-6 stream", 32'h340, 0, 7);
    wr(3'd0, 32'h20);

    // R9 cancel mid-transfer with a request in flight
    wr(3'd4, 32'd4); wr(3'd1, 32'h400); wr(3'd2, 32'd40); wr(3'd0, 32'h1);
    idle(40);
    pop_chk("R4 before cancel", fdat(32'h400));
    idle(2);
    wr(3'd0, 32'h2);
    rd_chk("R9 cancel clears busy, no done", 3'd0, 32'h0);
    rd_chk("R9 cancel empties FIFO", 3'd5, 32'd0);
    chk("R9 cancel drops request", 32'(fl_req), 32'd0);
    idle(10);
    rd_chk("R9 stale response discarded", 3'd5, 32'd0);
    wr(3'd0, 32'h2);
    rd_chk("R9 cancel while idle", 3'd0, 32'h0);

    // R2 start while busy ignored; start with cancel ignored
    wr(3'd0, 32'h3);
    rd_chk("R2 start with cancel ignored", 3'd0, 32'h0);
    wr(3'd1, 32'h500); wr(3'd2, 32'd20); wr(3'd0, 32'h1);
    idle(2);
    wr(3'd1, 32'h600); wr(3'd2, 32'd4); wr(3'd0, 32'h1);
    drain("R2 restart ignored while busy", 32'h500, 0, 5);
    rd_chk("R2 R7 done after five words", 3'd0, 32'h20);
    wr(3'd0, 32'h20);

    // R11 zero-length start
    wr(3'd2, 32'd0); wr(3'd0, 32'h1);
    rd_chk("R11 zero count sets done only", 3'd0, 32'h20);
    idle(5);
    chk("R11 no request for zero count", 32'(fl_req), 32'd0);
    wr(3'd0, 32'h20);

    // R4 pop on empty ignored, then a clean one-word transfer
    rd_pop = 1'b1; idle(1); rd_pop = 1'b0;
    rd_chk("R4 pop on empty ignored", 3'd5, 32'd0);
    wr(3'd1, 32'h700); wr(3'd2, 32'd4); wr(3'd0, 32'h1);
    drain("R4 after empty pop", 32'h700, 0, 1);
    rd_chk("R7 single-word done", 3'd0, 32'h20);
    idle(4);
    finish_run();
  end
endmodule